// File: doc/BRIEF.md
# Completion Ring Pointer Manager

This block keeps the producer side of one completion ring that lives in host memory. Once a configuration write has set the ring's base address, depth, entry size, interrupt enable and vector, the block accepts completions over a valid/ready handshake. For each one it issues a single memory-write request carrying the slot address and the entry fields, then moves its tail pointer forward. The host never reads a count. It tells new entries from stale ones by a phase bit that the block places in every entry and inverts each time the tail wraps.

The host returns consumed slots by writing a new head value to a doorbell port. A head value that lies outside the ring is dropped. A valid head value can free a ring that was full. When that happens the block emits a one-cycle resume pulse so that upstream submission processing and held-back completions can proceed. Interrupts leave as one-cycle pulses tagged with the configured vector. They fire after a doorbell that leaves unread entries, and at the end of each burst of posted completions. The bus write engine and the interrupt controller sit outside this block.

Top module: `cq_ptr_mgr`

## Requirements
- R1: After reset the block is unconfigured. push_ready is 0, and wr_valid, irq_pulse and resume_pulse are 0.
- R2: A configuration write sets tail and head to 0 and the phase bit to 1. Ring depth is cfg_qsize plus 1. The first posted entry goes to cfg_base with status bit 0 equal to 1.
- R3: A completion is accepted when push_valid and push_ready are both high. In the next cycle wr_valid is high for one cycle with wr_addr equal to base plus tail shifted left by cfg_esz_log2. The tail then advances by one.
- R4: wr_status is the 15-bit completion code in bits 15:1 and the current phase bit in bit 0.
- R5: When the tail passes the last slot (depth minus 1) it wraps to 0 and the phase bit inverts. Entries written after the wrap carry phase 0, then 1 after the next wrap, and so on.
- R6: The ring is full when (tail + 1) modulo depth equals head. While full, or during a configuration write, push_ready is 0 and no write request is issued.
- R7: A doorbell value greater than or equal to the depth is ignored. Head stays unchanged, so a full ring stays full.
- R8: A valid doorbell that arrives while the ring is full produces a one-cycle resume_pulse in the next cycle.
- R9: A valid doorbell whose value differs from the tail (after any same-cycle post) raises irq_pulse in the next cycle, if interrupts are enabled. A doorbell that equals the tail raises none.
- R10: When a cycle with no accepted completion follows one or more accepted completions, irq_pulse rises in the next cycle if interrupts are enabled. It never rises while they are disabled. irq_vector then equals the configured vector.
- R11: Each write request carries the submitting queue's id on wr_sqid and that queue's head on wr_sqhead, both as given with the completion.
- R12: While unconfigured, completions and doorbells have no effect: no write request, no resume and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_base | input | 64 | Ring base address |
| cfg_qsize | input | 12 | Ring depth minus one |
| cfg_esz_log2 | input | 4 | Log2 of entry size in bytes |
| cfg_ien | input | 1 | Interrupt enable |
| cfg_vector | input | 6 | Interrupt vector number |
| push_valid | input | 1 | Completion offered |
| push_ready | output | 1 | Completion can be accepted |
| push_code | input | 15 | Completion status code |
| push_sqid | input | 16 | Originating submission queue id |
| push_sqhead | input | 16 | Head of originating submission queue |
| db_valid | input | 1 | Head doorbell write strobe |
| db_head | input | 16 | New head value from host |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | 64 | Entry address |
| wr_status | output | 16 | Status halfword with phase in bit 0 |
| wr_sqid | output | 16 | Submission queue id for the entry |
| wr_sqhead | output | 16 | Submission queue head for the entry |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 6 | Vector accompanying irq_pulse |
| resume_pulse | output | 1 | Ring left the full state |

## Verification
The bench drives the ring to full and holds a completion against it, so a design with an off-by-one full test would overwrite an unread slot and issue an extra write. It wraps the tail more than once. An inverted or misplaced phase flip shows up as a wrong bit 0 or a wrong address on the first entry after the wrap. Doorbells equal to the depth test the bounds check, which a design using greater-than alone would accept. A doorbell equal to the tail must stay silent, or spurious interrupts result. Running with interrupts disabled and issuing traffic before configuration both catch pulses that escape their gating.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int ADDR_W = 64;
    localparam int PTR_W  = 12;
    localparam int DB_W   = 16;
    localparam int SC_W   = 15;
    localparam int QID_W  = 16;
    localparam int VEC_W  = 6;
    localparam int ESZ_W  = 4;
    localparam int STS_W  = SC_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ESZ_W-1:0]  esz_log2;
        logic              ien;
        logic [VEC_W-1:0]  vector;
    } cq_cfg_t;

    typedef struct packed {
        logic [SC_W-1:0]  code;
        logic [QID_W-1:0] sqid;
        logic [QID_W-1:0] sqhead;
    } cq_push_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [STS_W-1:0]  status;
        logic [QID_W-1:0]  sqid;
        logic [QID_W-1:0]  sqhead;
    } cq_wr_t;

    function automatic logic [PTR_W-1:0] ring_step(input logic [PTR_W-1:0] p,
                                                   input logic [PTR_W-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [STS_W-1:0] pack_status(input logic [SC_W-1:0] code,
                                                     input logic ph);
        return {code, ph};
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [PTR_W-1:0]  idx,
                                                    input logic [ESZ_W-1:0]  esz);
        return base + (ADDR_W'(idx) << esz);
    endfunction

endpackage

// File: rtl/cq_ring_ptrs.sv
module cq_ring_ptrs
    import cq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [PTR_W-1:0] cfg_last,
    input  logic             advance,
    input  logic             db_valid,
    input  logic [DB_W-1:0]  db_val,
    output logic [PTR_W-1:0] tail,
    output logic             phase,
    output logic             configured,
    output logic             full,
    output logic             db_ok,
    output logic             db_gap
);

    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] last_q;
    logic [PTR_W-1:0] tail_nxt;

    always_comb begin
        full     = configured && (ring_step(tail, last_q) == head);
        tail_nxt = advance ? ring_step(tail, last_q) : tail;
        db_ok    = configured && !cfg_load && db_valid && (db_val <= DB_W'(last_q));
        db_gap   = (DB_W'(tail_nxt) != db_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            configured <= 1'b0;
            last_q     <= '0;
            tail       <= '0;
            head       <= '0;
            phase      <= 1'b1;
        end else if (cfg_load) begin
            configured <= 1'b1;
            last_q     <= cfg_last;
            tail       <= '0;
            head       <= '0;
            phase      <= 1'b1;
        end else begin
            if (advance) begin
                tail <= tail_nxt;
                if (tail == last_q) phase <= ~phase;
            end
            if (db_ok) head <= db_val[PTR_W-1:0];
        end
    end

    // R5: leaving the last slot returns to slot 0 with the phase inverted
    a_r5_wrap_flips_phase: assert property (@(posedge clk) disable iff (rst)
        (advance && !cfg_load && tail == last_q) |=> (tail == '0 && phase != $past(phase)));

    // R6: the producer never overruns the consumer
    a_r6_never_overrun: assert property (@(posedge clk) disable iff (rst)
        full |-> !advance);

    // R7: an out-of-range doorbell leaves head untouched
    a_r7_oob_head_ignored: assert property (@(posedge clk) disable iff (rst)
        (db_valid && !cfg_load && db_val > DB_W'(last_q)) |=> $stable(head));

endmodule

// File: rtl/cq_entry_fmt.sv
module cq_entry_fmt
    import cq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  cq_cfg_t          cfg,
    input  logic [PTR_W-1:0] slot,
    input  logic             phase,
    input  cq_push_t         push,
    output logic             wr_valid,
    output cq_wr_t           wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr       <= '0;
        end else begin
            wr_valid <= accept;
            if (accept) begin
                wr.addr   <= slot_addr(cfg.base, slot, cfg.esz_log2);
                wr.status <= pack_status(push.code, phase);
                wr.sqid   <= push.sqid;
                wr.sqhead <= push.sqhead;
            end
        end
    end

    // R4: the emitted phase bit is the ring phase at acceptance
    a_r4_phase_in_status: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr.status[0] == $past(phase)));

endmodule

// File: rtl/cq_irq_gen.sv
module cq_irq_gen
    import cq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             ien,
    input  logic [VEC_W-1:0] vector,
    input  logic             db_ok,
    input  logic             db_gap,
    input  logic             was_full,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector,
    output logic             resume_pulse
);

    logic posted_q;
    logic batch_end;
    logic db_notify;

    always_comb begin
        batch_end = posted_q && !accept;
        db_notify = db_ok && db_gap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            posted_q     <= 1'b0;
            irq_pulse    <= 1'b0;
            irq_vector   <= '0;
            resume_pulse <= 1'b0;
        end else begin
            posted_q     <= accept;
            irq_pulse    <= ien && (batch_end || db_notify);
            irq_vector   <= vector;
            resume_pulse <= db_ok && was_full;
        end
    end

    // R10: no interrupt leaves while the queue has them disabled
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(ien));

    // R8: a resume follows only an accepted doorbell
    a_r8_resume_after_db: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |-> $past(db_ok));

endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr
    import cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [PTR_W-1:0]  cfg_qsize,
    input  logic [ESZ_W-1:0]  cfg_esz_log2,
    input  logic              cfg_ien,
    input  logic [VEC_W-1:0]  cfg_vector,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [SC_W-1:0]   push_code,
    input  logic [QID_W-1:0]  push_sqid,
    input  logic [QID_W-1:0]  push_sqhead,
    input  logic              db_valid,
    input  logic [DB_W-1:0]   db_head,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [STS_W-1:0]  wr_status,
    output logic [QID_W-1:0]  wr_sqid,
    output logic [QID_W-1:0]  wr_sqhead,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              resume_pulse
);

    cq_cfg_t          cfg_q;
    cq_push_t         push_in;
    cq_wr_t           wr_req;
    logic [PTR_W-1:0] tail;
    logic             phase;
    logic             configured;
    logic             full;
    logic             db_ok;
    logic             db_gap;
    logic             accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_valid) begin
            cfg_q.base     <= cfg_base;
            cfg_q.esz_log2 <= cfg_esz_log2;
            cfg_q.ien      <= cfg_ien;
            cfg_q.vector   <= cfg_vector;
        end
    end

    always_comb begin
        push_ready     = configured && !full && !cfg_valid;
        accept         = push_valid && push_ready;
        push_in.code   = push_code;
        push_in.sqid   = push_sqid;
        push_in.sqhead = push_sqhead;
        wr_addr        = wr_req.addr;
        wr_status      = wr_req.status;
        wr_sqid        = wr_req.sqid;
        wr_sqhead      = wr_req.sqhead;
    end

    cq_ring_ptrs u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .cfg_load   (cfg_valid),
        .cfg_last   (cfg_qsize),
        .advance    (accept),
        .db_valid   (db_valid),
        .db_val     (db_head),
        .tail       (tail),
        .phase      (phase),
        .configured (configured),
        .full       (full),
        .db_ok      (db_ok),
        .db_gap     (db_gap)
    );

    cq_entry_fmt u_fmt (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .cfg      (cfg_q),
        .slot     (tail),
        .phase    (phase),
        .push     (push_in),
        .wr_valid (wr_valid),
        .wr       (wr_req)
    );

    cq_irq_gen u_irq (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .ien          (cfg_q.ien),
        .vector       (cfg_q.vector),
        .db_ok        (db_ok),
        .db_gap       (db_gap),
        .was_full     (full),
        .irq_pulse    (irq_pulse),
        .irq_vector   (irq_vector),
        .resume_pulse (resume_pulse)
    );

    // R12: nothing is written while the ring is unconfigured
    a_r12_quiet_unconfigured: assert property (@(posedge clk) disable iff (rst)
        !configured |=> !wr_valid);

    // R1: no completion is offered a slot before configuration
    a_r1_not_ready_unconfigured: assert property (@(posedge clk) disable iff (rst)
        !configured |-> !push_ready);

endmodule

// File: tb/sim_cq_ptr_mgr.sv
`timescale 1ns/1ps
module sim_cq_ptr_mgr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [63:0] cfg_base = '0;
    logic [11:0] cfg_qsize = '0;
    logic [3:0]  cfg_esz_log2 = '0;
    logic        cfg_ien = 1'b0;
    logic [5:0]  cfg_vector = '0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [14:0] push_code = '0;
    logic [15:0] push_sqid = '0;
    logic [15:0] push_sqhead = '0;
    logic        db_valid = 1'b0;
    logic [15:0] db_head = '0;
    logic        wr_valid;
    logic [63:0] wr_addr;
    logic [15:0] wr_status;
    logic [15:0] wr_sqid;
    logic [15:0] wr_sqhead;
    logic        irq_pulse;
    logic [5:0]  irq_vector;
    logic        resume_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit started  = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    cq_ptr_mgr u0 (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
        .cfg_qsize(cfg_qsize), .cfg_esz_log2(cfg_esz_log2), .cfg_ien(cfg_ien),
        .cfg_vector(cfg_vector), .push_valid(push_valid), .push_ready(push_ready),
        .push_code(push_code), .push_sqid(push_sqid), .push_sqhead(push_sqhead),
        .db_valid(db_valid), .db_head(db_head), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_status(wr_status), .wr_sqid(wr_sqid),
        .wr_sqhead(wr_sqhead), .irq_pulse(irq_pulse), .irq_vector(irq_vector),
        .resume_pulse(resume_pulse)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_cfgd, m_phase, m_ien, m_posted;
    int          m_tail, m_head, m_last, m_esz;
    logic [63:0] m_base;
    logic [5:0]  m_vec;
    bit          e_wr, e_irq, e_resume;
    logic [63:0] e_addr;
    logic [15:0] e_status, e_sqid, e_sqhead;
    logic [5:0]  e_vec;
    string       e_irq_tag;

    function automatic bit model_full();
        int nx;
        nx = (m_tail == m_last) ? 0 : m_tail + 1;
        return m_cfgd && (nx == m_head);
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_cfgd = 0; m_phase = 1; m_ien = 0; m_posted = 0;
            m_tail = 0; m_head = 0; m_last = 0; m_esz = 0;
            m_base = '0; m_vec = '0;
            e_wr = 0; e_irq = 0; e_resume = 0; e_irq_tag = "R10";
        end else begin
            bit fl, acc, dbok, dbirq;
            int nt;
            fl    = model_full();
            acc   = m_cfgd && !fl && !cfg_valid && push_valid;
            dbok  = m_cfgd && !cfg_valid && db_valid && (int'(db_head) <= m_last);
            e_wr  = acc;
            if (acc) begin
                e_addr   = m_base + (64'(m_tail) << m_esz);
                e_status = {push_code, m_phase};
                e_sqid   = push_sqid;
                e_sqhead = push_sqhead;
            end
            nt = m_tail;
            if (acc) nt = (m_tail == m_last) ? 0 : m_tail + 1;
            dbirq     = dbok && (nt != int'(db_head));
            e_irq     = m_ien && (dbirq || (m_posted && !acc));
            e_irq_tag = dbirq ? "R9" : "R10";
            e_vec     = m_vec;
            e_resume  = dbok && fl;
            m_posted  = acc;
            if (cfg_valid) begin
                m_cfgd = 1; m_tail = 0; m_head = 0; m_phase = 1;
                m_last = int'(cfg_qsize); m_base = cfg_base; m_esz = int'(cfg_esz_log2);
                m_ien = cfg_ien; m_vec = cfg_vector;
            end else begin
                if (acc) begin
                    if (m_tail == m_last) m_phase = !m_phase;
                    m_tail = nt;
                end
                if (dbok) m_head = int'(db_head);
            end
        end
    end

    // per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (started && !done) begin
            bit er;
            er = m_cfgd && !model_full() && !cfg_valid;
            check(push_ready == er, !m_cfgd ? (push_valid ? "R12" : "R1") : "R6",
                  64'(push_ready), 64'(er));
            check(wr_valid == e_wr, "R3", 64'(wr_valid), 64'(e_wr));
            if (wr_valid && e_wr) begin
                check(wr_addr == e_addr, "R3", wr_addr, e_addr);
                check(wr_status == e_status, "R4", 64'(wr_status), 64'(e_status));
                check(wr_sqid == e_sqid && wr_sqhead == e_sqhead, "R11",
                      {32'h0, wr_sqid, wr_sqhead}, {32'h0, e_sqid, e_sqhead});
            end
            check(irq_pulse == e_irq, e_irq_tag, 64'(irq_pulse), 64'(e_irq));
            if (irq_pulse && e_irq)
                check(irq_vector == e_vec, "R10", 64'(irq_vector), 64'(e_vec));
            check(resume_pulse == e_resume, "R8", 64'(resume_pulse), 64'(e_resume));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_cfg(input logic [63:0] b, input logic [11:0] qs,
                          input logic [3:0] es, input logic ie, input logic [5:0] v);
        cfg_valid = 1; cfg_base = b; cfg_qsize = qs; cfg_esz_log2 = es;
        cfg_ien = ie; cfg_vector = v;
        step();
        cfg_valid = 0;
    endtask

    task automatic do_push(input logic [14:0] c, input logic [15:0] q, input logic [15:0] h);
        push_valid = 1; push_code = c; push_sqid = q; push_sqhead = h;
        step();
        push_valid = 0;
    endtask

    task automatic do_db(input logic [15:0] h);
        db_valid = 1; db_head = h;
        step();
        db_valid = 0;
    endtask

    localparam logic [63:0] BASE_A = 64'h0000_0001_2000_0000;
    localparam logic [63:0] BASE_B = 64'h0000_0000_8000_4000;
    localparam logic [63:0] BASE_C = 64'h0000_00ff_0000_0000;

    initial begin
        #1600000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2;
        repeat (3) step();
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check(!push_ready && !wr_valid && !irq_pulse && !resume_pulse, "R1",
              {60'h0, push_ready, wr_valid, irq_pulse, resume_pulse}, 64'h0);

        // R12: traffic before configuration
        do_push(15'h7, 16'd1, 16'd1);
        @(negedge clk);
        check(!wr_valid, "R12", 64'(wr_valid), 64'h0);
        do_db(16'd0);
        @(negedge clk);
        check(!resume_pulse && !irq_pulse, "R12", {62'h0, resume_pulse, irq_pulse}, 64'h0);

        // depth 4, 16-byte entries, interrupts on, vector 9
        do_cfg(BASE_A, 12'd3, 4'd4, 1'b1, 6'd9);
        do_push(15'h0, 16'd3, 16'd7);
        @(negedge clk);
        check(wr_valid && wr_addr == BASE_A && wr_status == 16'h0001, "R2",
              wr_addr, BASE_A);
        do_push(15'h2, 16'd3, 16'd8);
        @(negedge clk);
        check(wr_addr == BASE_A + 64'd16, "R3", wr_addr, BASE_A + 64'd16);
        check(wr_status == 16'h0005, "R4", 64'(wr_status), 64'h5);
        check(wr_sqid == 16'd3 && wr_sqhead == 16'd8, "R11",
              {32'h0, wr_sqid, wr_sqhead}, {32'h0, 16'd3, 16'd8});
        do_push(15'h1, 16'd3, 16'd9);
        @(negedge clk);
        check(!push_ready, "R6", 64'(push_ready), 64'h0);

        // hold a completion against the full ring
        push_valid = 1; push_code = 15'h3;
        repeat (3) step();
        push_valid = 0;
        @(negedge clk);
        check(!wr_valid, "R6", 64'(wr_valid), 64'h0);

        // R7: doorbell equal to the depth is dropped
        do_db(16'd4);
        @(negedge clk);
        check(!push_ready && !resume_pulse, "R7", {62'h0, push_ready, resume_pulse}, 64'h0);

        // R8 / R9: valid head frees the ring, tail 3 differs from head 2
        do_db(16'd2);
        @(negedge clk);
        check(resume_pulse, "R8", 64'(resume_pulse), 64'h1);
        check(irq_pulse && irq_vector == 6'd9, "R9", {57'h0, irq_pulse, irq_vector},
              {57'h0, 1'b1, 6'd9});

        // R5: wrap the tail
        do_push(15'h4, 16'd2, 16'd0);
        do_push(15'h5, 16'd2, 16'd1);
        @(negedge clk);
        check(wr_addr == BASE_A && wr_status[0] == 1'b0, "R5", wr_addr, BASE_A);
        step();
        step();
        // head catches up with tail 1: no interrupt
        do_db(16'd1);
        @(negedge clk);
        check(!irq_pulse, "R9", 64'(irq_pulse), 64'h0);

        // R10: interrupts disabled
        do_cfg(BASE_B, 12'd7, 4'd6, 1'b0, 6'd3);
        do_push(15'h11, 16'd5, 16'd1);
        do_push(15'h12, 16'd5, 16'd2);
        do_push(15'h13, 16'd5, 16'd3);
        @(negedge clk);
        check(wr_addr == BASE_B + 64'd128, "R3", wr_addr, BASE_B + 64'd128);
        step();
        @(negedge clk);
        check(!irq_pulse, "R10", 64'(irq_pulse), 64'h0);
        step();
        @(negedge clk);
        check(!irq_pulse, "R10", 64'(irq_pulse), 64'h0);

        // mixed traffic, depth 6, several wraps and stray doorbells
        do_cfg(BASE_C, 12'd5, 4'd5, 1'b1, 6'd1);
        for (int i = 0; i < 600; i++) begin
            push_valid  = ($urandom % 3) != 0;
            push_code   = 15'($urandom);
            push_sqid   = 16'($urandom % 8);
            push_sqhead = 16'($urandom);
            db_valid    = ($urandom % 4) == 0;
            db_head     = 16'($urandom % 8);
            step();
        end
        push_valid = 0;
        db_valid   = 0;
        repeat (4) step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule